// File: doc/BRIEF.md
# Programmable ROM Strobe Timing Generator

This block shapes the control waveforms for one access to an external parallel ROM. A start pulse, sampled together with a read/write flag, opens an access. Chip select drops for a programmed number of clock cycles, and the read or write strobe is driven low during those parts of the window that an 8-bit shape mask enables. The access length is taken from a four-entry table picked by a 2-bit select, and a speed-mode bit doubles every entry for clocks faster than 33 MHz.

The mask splits the window into eight equal slices. Mask bit 0 governs the first slice and bit 7 the last. A one-cycle done pulse follows the release of chip select. The controller that holds the settings, the address and data path, and data capture are outside the block. All settings arrive on plain input ports and are captured when an access starts.

Top module: `rom_strobe_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active low), the next cycle shows `rom_cs_n`, `rom_rd_n` and `rom_wr_n` high and `busy` and `done` low.
- R2: When `acc_start` is high at a rising edge while the block is idle, `rom_cs_n` is low from the following cycle on.
- R3: With `fast_clk` = 0, `len_sel` values 0, 1, 2 and 3 hold `rom_cs_n` low for 8, 16, 64 and 256 consecutive cycles.
- R4: With `fast_clk` = 1, `len_sel` values 0, 1, 2 and 3 hold `rom_cs_n` low for 16, 32, 128 and 512 consecutive cycles.
- R5: Access cycle c (counted from 0) falls in slice c / (length/8). The active strobe is low in that cycle exactly when `strobe_mask[slice]` is 1. Bit 0 is the first slice.
- R6: `acc_write` = 0 selects a read, so only `rom_rd_n` may go low. `acc_write` = 1 selects a write, so only `rom_wr_n` may go low. The other strobe stays high for the whole access.
- R7: `acc_write`, `fast_clk`, `len_sel` and `strobe_mask` are captured at the start edge. Changing them during an access alters neither its length nor its strobe shape.
- R8: `busy` is high in exactly the cycles in which `rom_cs_n` is low. A start request that arrives while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle: the first cycle after `rom_cs_n` returns high. A start request made during that cycle is accepted, and chip select drops in the next cycle.
- R10: With the suggested defaults (`strobe_mask` = 8'b01111110, `len_sel` = 0, `fast_clk` = 0), a read runs as follows: cycle 1 has chip select alone, cycles 2 to 7 have chip select and strobe, cycle 8 has chip select alone, and chip select is released after cycle 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_start | input | 1 | Request to begin an access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| fast_clk | input | 1 | 1 when the clock runs above 33 MHz; doubles all lengths |
| len_sel | input | 2 | Picks the access length from the table |
| strobe_mask | input | 8 | Strobe shape, one bit per eighth of the window |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_wr_n | output | 1 | ROM write strobe, active low |
| busy | output | 1 | High while an access is in progress |
| done | output | 1 | One-cycle pulse after chip select is released |

## Verification
The assertions assume that `acc_start` and the settings are synchronous to `clk` and that reset is low for at least one rising edge. The start-edge check also assumes that a start seen while idle always opens an access, whatever the settings. The bench drives every input on the falling edge, so no input changes near a rising edge. During accesses it scrambles the settings and pulses start at random, but it always clears start before the done cycle unless it is deliberately testing a back-to-back start.

// File: rtl/rom_strobe_gen.sv
module rom_strobe_gen #(
  parameter int SLICES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              acc_write,
  input  logic              fast_clk,
  input  logic [1:0]        len_sel,
  input  logic [SLICES-1:0] strobe_mask,
  output logic              rom_cs_n,
  output logic              rom_rd_n,
  output logic              rom_wr_n,
  output logic              busy,
  output logic              done
);
  localparam int SL_LOG = $clog2(SLICES);
  localparam int MAX_SH = 6;
  localparam int CNT_W  = SL_LOG + MAX_SH;

  function automatic logic [2:0] slice_log(input logic [1:0] s, input logic f);
    logic [2:0] b;
    case (s)
      2'd0:    b = 3'd0;
      2'd1:    b = 3'd1;
      2'd2:    b = 3'd3;
      default: b = 3'd5;
    endcase
    return b + {2'b0, f};
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic [2:0]        sh_q;
  logic [SLICES-1:0] mask_q;
  logic              wr_q;

  wire [CNT_W-1:0]  last_idx = ~({CNT_W{1'b1}} << (SL_LOG + int'(sh_q)));
  wire [CNT_W-1:0]  nxt      = cnt + 1'b1;
  wire [SL_LOG-1:0] nxt_sl   = SL_LOG'(nxt >> sh_q);
  wire              nxt_on   = mask_q[nxt_sl];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh_q     <= '0;
      mask_q   <= '0;
      wr_q     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rom_cs_n <= 1'b1;
      rom_rd_n <= 1'b1;
      rom_wr_n <= 1'b1;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == last_idx) begin
          cnt      <= '0;
          busy     <= 1'b0;
          done     <= 1'b1;
          rom_cs_n <= 1'b1;
          rom_rd_n <= 1'b1;
          rom_wr_n <= 1'b1;
        end else begin
          cnt      <= nxt;
          rom_rd_n <= !(!wr_q && nxt_on);
          rom_wr_n <= !( wr_q && nxt_on);
        end
      end else if (acc_start) begin
        cnt      <= '0;
        busy     <= 1'b1;
        sh_q     <= slice_log(len_sel, fast_clk);
        mask_q   <= strobe_mask;
        wr_q     <= acc_write;
        rom_cs_n <= 1'b0;
        rom_rd_n <= !(!acc_write && strobe_mask[0]);
        rom_wr_n <= !( acc_write && strobe_mask[0]);
      end
    end
  end
endmodule

module rom_strobe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_start,
  input logic rom_cs_n,
  input logic rom_rd_n,
  input logic rom_wr_n,
  input logic busy,
  input logic done
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (rom_cs_n && rom_rd_n && rom_wr_n && !busy && !done));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_rd_n && !rom_wr_n));

  // R5
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_rd_n || !rom_wr_n) |-> !rom_cs_n);

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_cs_n) |-> ($past(acc_start) && !$past(busy)));

  // R9
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rom_cs_n && !$past(rom_cs_n)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind rom_strobe_gen rom_strobe_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .rom_cs_n(rom_cs_n),
  .rom_rd_n(rom_rd_n), .rom_wr_n(rom_wr_n), .busy(busy), .done(done)
);

// File: tb/rom_strobe_gen_tb.sv
`timescale 1ns/1ps
module rom_strobe_gen_tb;
  logic clk = 0, rst_n = 0, acc_start = 0, acc_write = 0, fast_clk = 0;
  logic [1:0] len_sel = 0;
  logic [7:0] strobe_mask = 8'b01111110;
  logic rom_cs_n, rom_rd_n, rom_wr_n, busy, done;

  int nchk = 0, nfail = 0;
  bit chk_on = 0, finished = 0;

  always #4 clk = ~clk;

  rom_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_write(acc_write),
    .fast_clk(fast_clk), .len_sel(len_sel), .strobe_mask(strobe_mask),
    .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_wr_n(rom_wr_n),
    .busy(busy), .done(done));

  function automatic int len_of(input logic [1:0] s, input logic f);
    int l;
    case (s)
      2'd0: l = 8;
      2'd1: l = 16;
      2'd2: l = 64;
      default: l = 256;
    endcase
    return f ? 2 * l : l;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_pos = -1, m_len = 8, m_slice = 1, m_done = 0;
  logic [7:0] m_mask = 0;
  logic m_wr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = -1; m_done = 0;
    end else begin
      m_done = 0;
      if (m_pos >= 0) begin
        if (m_pos == m_len - 1) begin m_pos = -1; m_done = 1; end
        else m_pos++;
      end else if (acc_start) begin
        m_len = len_of(len_sel, fast_clk);
        m_slice = m_len / 8;
        m_mask = strobe_mask;
        m_wr = acc_write;
        m_pos = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !finished) begin
      bit act_on, e_cs, e_rd, e_wr;
      act_on = (m_pos >= 0) && m_mask[m_pos / m_slice];
      e_cs = !(m_pos >= 0);
      e_rd = !(act_on && !m_wr);
      e_wr = !(act_on && m_wr);
      check(rom_cs_n == e_cs, "R2 cs", rom_cs_n, e_cs);
      check(rom_rd_n == e_rd, "R5/R6 rd", rom_rd_n, e_rd);
      check(rom_wr_n == e_wr, "R5/R6 wr", rom_wr_n, e_wr);
      check(busy == !e_cs, "R8 busy", busy, !e_cs);
      check(done == (m_done == 1), "R9 done", done, m_done);
    end
  end

  // runs one access; disturb scrambles settings and pulses start while busy
  task automatic access(input logic w, input logic [1:0] s, input logic f,
                        input logic [7:0] m, input bit disturb, input string req);
    int n;
    @(negedge clk);
    acc_write = w; len_sel = s; fast_clk = f; strobe_mask = m; acc_start = 1;
    @(negedge clk);
    acc_start = 0;
    n = 0;
    while (rom_cs_n == 0 && n < 1000) begin
      n++;
      if (disturb) begin
        acc_write = $urandom; len_sel = $urandom; fast_clk = $urandom;
        strobe_mask = $urandom; acc_start = $urandom;
      end
      @(negedge clk);
    end
    acc_start = 0;
    check(n == len_of(s, f), req, n, len_of(s, f));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rom_cs_n && rom_rd_n && rom_wr_n && !busy && !done, "R1 reset",
          {rom_cs_n, rom_rd_n, rom_wr_n, busy, done}, 5'b11100);
    rst_n = 1;
    chk_on = 1;

    // R10 default read timeline
    begin
      logic [7:0] cs_t, rd_t;
      @(negedge clk);
      acc_write = 0; len_sel = 0; fast_clk = 0; strobe_mask = 8'b01111110; acc_start = 1;
      @(negedge clk);
      acc_start = 0;
      for (int i = 0; i < 8; i++) begin
        cs_t[i] = rom_cs_n; rd_t[i] = rom_rd_n;
        @(negedge clk);
      end
      check(cs_t == 8'h00, "R10 cs", cs_t, 0);
      check(rd_t == 8'b10000001, "R10 rd", rd_t, 8'b10000001);
      check(rom_cs_n == 1, "R10 release", rom_cs_n, 1);
    end

    // R3 low-speed lengths
    for (int s = 0; s < 4; s++) access(s[0], 2'(s), 0, 8'hA5 ^ 8'(s), 0, "R3 length");
    // R4 high-speed lengths
    for (int s = 0; s < 4; s++) access(!s[0], 2'(s), 1, 8'h3C + 8'(s), 0, "R4 length");
    // R5/R6 assorted masks
    access(0, 1, 0, 8'h01, 0, "R5 length");
    access(1, 1, 1, 8'h80, 0, "R5 length");
    access(1, 2, 0, 8'hFF, 0, "R6 length");
    access(0, 0, 1, 8'h00, 0, "R6 length");
    // R7/R8 settings held, start ignored while busy
    for (int k = 0; k < 6; k++)
      access(k[0], 2'(k % 3), k[1], 8'($urandom), 1, "R7 length");

    // R9 back-to-back: start during done cycle
    access(0, 0, 0, 8'h5A, 0, "R9 length");
    check(done == 1, "R9 pulse", done, 1);
    acc_start = 1; acc_write = 1; strobe_mask = 8'hF0;
    @(negedge clk);
    acc_start = 0;
    check(rom_cs_n == 0, "R9 restart", rom_cs_n, 0);
    repeat (20) @(negedge clk);

    // R1 reset mid-access
    acc_start = 1; len_sel = 3; fast_clk = 1; strobe_mask = 8'hFF; acc_write = 0;
    @(negedge clk);
    acc_start = 0;
    repeat (10) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(rom_cs_n && rom_rd_n && rom_wr_n && !busy, "R1 mid reset",
          {rom_cs_n, rom_rd_n, rom_wr_n, busy}, 4'b1110);
    rst_n = 1;
    repeat (5) @(negedge clk);
    access(0, 0, 0, 8'h7E, 0, "R1 after reset");

    chk_on = 0;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule